// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits beside a CPU core and decides, once per machine cycle, whether the core should take an interrupt and which one. It holds a per-source enable mask, a global enable and two priority bit vectors. The two priority vectors combine into a 2-bit level for every source. Each cycle it masks the incoming request flags, picks the strongest request and compares it with the level of the routine currently running. It raises a one-cycle vector strobe with the service address when the core reports a point where an interrupt may be taken.

Nesting is tracked with one in-service bit per level. Vectoring sets the winner's bit. A return-from-interrupt pulse from the core clears the highest set bit. Requests are never latched: a flag counts only if it is high in the cycle where every condition holds. On vectoring, the block also tells the winning source whether its flag should be cleared by hardware. That depends on the source's kind, which is fixed by a parameter, and for external inputs on their edge/level setting.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the enable mask, global enable, both priority vectors and the in-service bits are 0, and `vec_stb` and `flag_clr` are 0. With the reset configuration, no flag pattern produces a vector.
- R2: A source's level is {high bit, low bit} from the two priority vectors, 0 lowest and 3 highest. Among eligible requests the highest level wins, whatever the source index.
- R3: Among eligible requests sharing the highest level, the lowest source index wins.
- R4: A source with its enable bit at 0 never wins. When the global enable is 0, no source wins.
- R5: A vector is taken only in a cycle where `instr_last` is 1.
- R6: No vector is taken in a cycle where `instr_blocks` or `reti` is 1.
- R7: Requests are not remembered. A flag that was high only in cycles where vectoring was not allowed is never serviced.
- R8: A vector taken in cycle t sets `vec_stb` for exactly cycle t+1. In that cycle `vec_addr` equals 0x0003 + 8 × winning index.
- R9: A vector sets the winner's level bit in `insvc` (bit n = level n). It is taken only when `insvc` is 0 or the winner's level is strictly above the highest set bit. A level-3 routine is never preempted.
- R10: A `reti` pulse clears the highest set bit of `insvc`. With `insvc` at 0 it has no effect.
- R11: With a vector, `flag_clr` has at most the winner's bit set. Timer-kind sources are always cleared. External-kind sources are cleared only when their `ext_edge` bit is 1. Software-kind sources are never cleared. The default kinds are: index 0 and 2 external, 1 and 3 timer, 4 to 7 software.
- R12: A write with `cfg_wr`=1 stores `cfg_wdata` into the field chosen by `cfg_sel`: 0 = enable mask, 1 = low priority bits, 2 = high priority bits, 3 = global enable (bit 0). The new value is used by arbitration from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_flag | input | NUM_SRC | Request flags, sampled every cycle |
| ext_edge | input | NUM_SRC | Edge-triggered setting per source (used by external kinds) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration field select |
| cfg_wdata | input | NUM_SRC | Configuration write data |
| instr_last | input | 1 | Current cycle is the last of the instruction |
| instr_blocks | input | 1 | Current instruction writes an enable or priority register |
| reti | input | 1 | Return-from-interrupt pulse |
| vec_stb | output | 1 | One-cycle vector request |
| vec_addr | output | ADDR_W | Service address for the vector |
| flag_clr | output | NUM_SRC | Hardware clear for the winning source's flag |
| insvc | output | 4 | In-service bit per level |

## Verification
Some rules are checked by assertions on every cycle. A strobe may only follow a cycle that allowed vectoring. Each strobe adds exactly one in-service bit, and each return removes one. A level-3 routine is never followed by a strobe. Clear pulses come only with a strobe and are at most one-hot. The bench scenarios are needed to show which source wins. They cover level ordering, index tie-break, masking, the absence of request memory, the address values, the per-kind clear policy and the one-cycle delay of configuration writes.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

   localparam int NUM_LVL = 4;

   typedef logic [1:0] lvl_t;

   typedef enum logic [1:0] {
      CFG_ENABLE  = 2'd0,
      CFG_PRIO_LO = 2'd1,
      CFG_PRIO_HI = 2'd2,
      CFG_GLOBAL  = 2'd3
   } cfg_sel_e;

   typedef enum logic [1:0] {
      KIND_SW    = 2'd0,
      KIND_TIMER = 2'd1,
      KIND_EXT   = 2'd2
   } src_kind_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_nest_pkg::*;
#(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  cfg_sel_e           sel,
   input  logic [NUM_SRC-1:0] wdata,
   output logic [NUM_SRC-1:0] en_mask,
   output logic               glb_en,
   output logic [NUM_SRC-1:0] prio_lo,
   output logic [NUM_SRC-1:0] prio_hi
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_mask <= '0;
         glb_en  <= 1'b0;
         prio_lo <= '0;
         prio_hi <= '0;
      end else if (wr) begin
         unique case (sel)
            CFG_ENABLE:  en_mask <= wdata;
            CFG_PRIO_LO: prio_lo <= wdata;
            CFG_PRIO_HI: prio_hi <= wdata;
            CFG_GLOBAL:  glb_en  <= wdata[0];
            default:     glb_en  <= glb_en;
         endcase
      end
   end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
   import irq_nest_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3
) (
   input  logic [NUM_SRC-1:0] req,
   input  logic [NUM_SRC-1:0] prio_lo,
   input  logic [NUM_SRC-1:0] prio_hi,
   output logic               found,
   output logic [IDX_W-1:0]   win_idx,
   output lvl_t               win_lvl
);

   // Walk from the top index down; ">=" lets a lower index take a tie.
   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i] && (!found || {prio_hi[i], prio_lo[i]} >= win_lvl)) begin
            found   = 1'b1;
            win_lvl = {prio_hi[i], prio_lo[i]};
            win_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/irq_insvc_track.sv
module irq_insvc_track
   import irq_nest_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  lvl_t               push_lvl,
   input  logic               pop,
   output logic [NUM_LVL-1:0] insvc,
   output logic               busy,
   output lvl_t               cur_lvl
);

   logic [NUM_LVL-1:0] top_hot;

   always_comb begin
      cur_lvl = '0;
      top_hot = '0;
      for (int l = 0; l < NUM_LVL; l++) begin
         if (insvc[l]) begin
            cur_lvl = lvl_t'(l);
            top_hot = NUM_LVL'(1) << l;
         end
      end
   end

   assign busy = |insvc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         insvc <= '0;
      end else if (pop) begin
         insvc <= insvc & ~top_hot;
      end else if (push) begin
         insvc <= insvc | (NUM_LVL'(1) << push_lvl);
      end
   end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
   import irq_nest_pkg::*;
#(
   parameter int                  NUM_SRC    = 8,
   parameter int                  ADDR_W     = 16,
   parameter int                  VEC_BASE   = 3,
   parameter int                  VEC_STRIDE = 8,
   parameter logic [2*NUM_SRC-1:0] SRC_KIND  = 16'h0066
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_flag,
   input  logic [NUM_SRC-1:0] ext_edge,
   input  logic               cfg_wr,
   input  logic [1:0]         cfg_sel,
   input  logic [NUM_SRC-1:0] cfg_wdata,
   input  logic               instr_last,
   input  logic               instr_blocks,
   input  logic               reti,
   output logic               vec_stb,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic [NUM_SRC-1:0] flag_clr,
   output logic [3:0]         insvc
);

   localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int TOP_ADDR = VEC_BASE + VEC_STRIDE * (NUM_SRC - 1);

   // Elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_num
      $error("irq_nest_ctrl: NUM_SRC must be 1..64");
   end
   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_aw
      $error("irq_nest_ctrl: ADDR_W must be 2..32");
   end
   if (ADDR_W < 32 && TOP_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_map
      $error("irq_nest_ctrl: vector table exceeds ADDR_W");
   end
   if (NUM_LVL != 4) begin : g_bad_lvl
      $error("irq_nest_ctrl: tracker width must match insvc port");
   end

   logic [NUM_SRC-1:0] en_mask, prio_lo, prio_hi, req_q;
   logic               glb_en, found, busy, take;
   logic [IDX_W-1:0]   win_idx;
   lvl_t               win_lvl, cur_lvl;
   logic [NUM_SRC-1:0] clr_ok;

   irq_cfg_regs #(.NUM_SRC(NUM_SRC)) cfg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cfg_wr),
      .sel     (cfg_sel_e'(cfg_sel)),
      .wdata   (cfg_wdata),
      .en_mask (en_mask),
      .glb_en  (glb_en),
      .prio_lo (prio_lo),
      .prio_hi (prio_hi)
   );

   assign req_q = irq_flag & en_mask & {NUM_SRC{glb_en}};

   irq_prio_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) arb_i (
      .req     (req_q),
      .prio_lo (prio_lo),
      .prio_hi (prio_hi),
      .found   (found),
      .win_idx (win_idx),
      .win_lvl (win_lvl)
   );

   irq_insvc_track trk_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (take),
      .push_lvl (win_lvl),
      .pop      (reti),
      .insvc    (insvc),
      .busy     (busy),
      .cur_lvl  (cur_lvl)
   );

   assign take = found && instr_last && !instr_blocks && !reti &&
                 (!busy || (win_lvl > cur_lvl));

   // Per-source hardware-clear policy chosen by kind
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
      localparam logic [1:0] KIND = SRC_KIND[2*g +: 2];
      if (KIND == KIND_TIMER) begin : g_timer
         assign clr_ok[g] = 1'b1;
      end else if (KIND == KIND_EXT) begin : g_ext
         assign clr_ok[g] = ext_edge[g];
      end else begin : g_sw
         assign clr_ok[g] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_stb  <= 1'b0;
         vec_addr <= '0;
         flag_clr <= '0;
      end else begin
         vec_stb  <= take;
         flag_clr <= take ? ((NUM_SRC'(1) << win_idx) & clr_ok) : '0;
         if (take) begin
            vec_addr <= ADDR_W'(VEC_BASE + VEC_STRIDE * int'(win_idx));
         end
      end
   end

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
   parameter int NUM_SRC = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               instr_last,
   input logic               instr_blocks,
   input logic               reti,
   input logic               vec_stb,
   input logic [NUM_SRC-1:0] flag_clr,
   input logic [3:0]         insvc
);

   // R5 R6
   vec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_stb |-> $past(instr_last && !instr_blocks && !reti));

   // R9
   push_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_stb |-> ($countones(insvc) == $countones($past(insvc)) + 1));

   // R10
   pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && (insvc != 4'b0)) |=> ($countones(insvc) + 1 == $countones($past(insvc))));

   // R9
   top_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      insvc[3] |=> !vec_stb);

   // R11
   clr_with_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_stb |-> (flag_clr == '0));

   // R11
   clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flag_clr));

   // R8
   stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_stb |=> (!vec_stb || $past(instr_last)));

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .instr_last   (instr_last),
   .instr_blocks (instr_blocks),
   .reti         (reti),
   .vec_stb      (vec_stb),
   .flag_clr     (flag_clr),
   .insvc        (insvc)
);

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  irq_flag = '0, ext_edge = '0, cfg_wdata = '0, flag_clr;
   logic        cfg_wr = 1'b0, instr_last = 1'b0, instr_blocks = 1'b0, reti = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic        vec_stb;
   logic [15:0] vec_addr;
   logic [3:0]  insvc;
   int          n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   irq_nest_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .ext_edge(ext_edge),
      .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .instr_last(instr_last), .instr_blocks(instr_blocks), .reti(reti),
      .vec_stb(vec_stb), .vec_addr(vec_addr), .flag_clr(flag_clr), .insvc(insvc)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One machine cycle; outputs sampled at the following falling edge
   task automatic drive(input logic [7:0] f, input logic l, input logic b, input logic r);
      irq_flag = f; instr_last = l; instr_blocks = b; reti = r;
      @(negedge clk);
   endtask

   task automatic cfg(input logic [1:0] s, input logic [7:0] d);
      cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
      drive(8'h00, 1'b0, 1'b0, 1'b0);
      cfg_wr = 1'b0;
   endtask

   task automatic expect_vec(input string req, input logic [15:0] a,
                             input logic [7:0] c, input logic [3:0] s);
      check(req, {31'd0, vec_stb}, 32'd1);
      check(req, {16'd0, vec_addr}, {16'd0, a});
      check(req, {24'd0, flag_clr}, {24'd0, c});
      check(req, {28'd0, insvc}, {28'd0, s});
   endtask

   task automatic expect_none(input string req, input logic [3:0] s);
      check(req, {31'd0, vec_stb}, 32'd0);
      check(req, {24'd0, flag_clr}, 32'd0);
      check(req, {28'd0, insvc}, {28'd0, s});
   endtask

   task automatic do_reti(input logic [3:0] s);
      drive(8'h00, 1'b0, 1'b0, 1'b1);
      expect_none("R10 reti pop", s);
   endtask

   task automatic t_reset;
      check("R1 reset stb", {31'd0, vec_stb}, 32'd0);
      check("R1 reset insvc", {28'd0, insvc}, 32'd0);
      drive(8'hFF, 1'b1, 1'b0, 1'b0);
      expect_none("R1 reset config blocks all", 4'b0000);
      cfg(2'd3, 8'h01);
      cfg(2'd0, 8'hFF);
   endtask

   task automatic t_level;
      cfg(2'd1, 8'h04);   // src2 level 1
      cfg(2'd2, 8'h40);   // src6 level 2
      drive(8'h44, 1'b1, 1'b0, 1'b0);
      expect_vec("R2 higher level wins", 16'h0033, 8'h00, 4'b0100);
      drive(8'h00, 1'b0, 1'b0, 1'b0);
      expect_none("R8 strobe one cycle", 4'b0100);
      do_reti(4'b0000);
      cfg(2'd1, 8'h00);
      cfg(2'd2, 8'h00);
   endtask

   task automatic t_tie;
      drive(8'h28, 1'b1, 1'b0, 1'b0);
      expect_vec("R3 tie lowest index, R11 timer clear", 16'h001B, 8'h08, 4'b0001);
      do_reti(4'b0000);
   endtask

   task automatic t_gate;
      drive(8'h02, 1'b0, 1'b0, 1'b0);
      expect_none("R5 not last cycle", 4'b0000);
      drive(8'h02, 1'b1, 1'b1, 1'b0);
      expect_none("R6 blocking instr", 4'b0000);
      drive(8'h02, 1'b1, 1'b0, 1'b1);
      expect_none("R6 reti cycle, R10 empty pop", 4'b0000);
      drive(8'h00, 1'b1, 1'b0, 1'b0);
      expect_none("R7 no memory", 4'b0000);
      drive(8'h02, 1'b1, 1'b0, 1'b0);
      expect_vec("R8 address src1", 16'h000B, 8'h02, 4'b0001);
      do_reti(4'b0000);
   endtask

   task automatic t_mask;
      cfg(2'd0, 8'hFD);
      drive(8'h02, 1'b1, 1'b0, 1'b0);
      expect_none("R4 source disabled", 4'b0000);
      cfg(2'd0, 8'hFF);
      cfg(2'd3, 8'h00);
      drive(8'h01, 1'b1, 1'b0, 1'b0);
      expect_none("R4 global disabled", 4'b0000);
      cfg(2'd3, 8'h01);
   endtask

   task automatic t_nest;
      ext_edge = 8'h04;
      cfg(2'd2, 8'h84);   // src2 level 2, src7 level 3
      cfg(2'd1, 8'h90);   // src4 level 1
      drive(8'h10, 1'b1, 1'b0, 1'b0);
      expect_vec("R9 first level", 16'h0023, 8'h00, 4'b0010);
      drive(8'h01, 1'b1, 1'b0, 1'b0);
      expect_none("R9 lower blocked", 4'b0010);
      drive(8'h10, 1'b1, 1'b0, 1'b0);
      expect_none("R9 equal blocked", 4'b0010);
      drive(8'h04, 1'b1, 1'b0, 1'b0);
      expect_vec("R9 preempt, R11 ext edge clear", 16'h0013, 8'h04, 4'b0110);
      drive(8'h80, 1'b1, 1'b0, 1'b0);
      expect_vec("R9 level3 preempt, R11 sw no clear", 16'h003B, 8'h00, 4'b1110);
      drive(8'hFF, 1'b1, 1'b0, 1'b0);
      expect_none("R9 level3 not preempted", 4'b1110);
      do_reti(4'b0110);
      do_reti(4'b0010);
      drive(8'h01, 1'b1, 1'b0, 1'b0);
      expect_none("R10 still level1", 4'b0010);
      do_reti(4'b0000);
      drive(8'h01, 1'b1, 1'b0, 1'b0);
      expect_vec("R11 ext level no clear", 16'h0003, 8'h00, 4'b0001);
      do_reti(4'b0000);
      ext_edge = 8'h01;
      drive(8'h01, 1'b1, 1'b0, 1'b0);
      expect_vec("R11 ext edge clear", 16'h0003, 8'h01, 4'b0001);
      do_reti(4'b0000);
      cfg(2'd1, 8'h00);
      cfg(2'd2, 8'h00);
   endtask

   task automatic t_cfg_timing;
      cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'h00;
      drive(8'h08, 1'b1, 1'b0, 1'b0);
      cfg_wr = 1'b0;
      expect_vec("R12 old enable still used", 16'h001B, 8'h08, 4'b0001);
      do_reti(4'b0000);
      drive(8'h08, 1'b1, 1'b0, 1'b0);
      expect_none("R12 new enable applied", 4'b0000);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      irq_flag = 8'hFF; instr_last = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      irq_flag = 8'h00; instr_last = 1'b0;
      t_reset();
      t_level();
      t_tie();
      t_gate();
      t_mask();
      t_nest();
      t_cfg_timing();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule